// File: doc/BRIEF.md
# Flash Program Request Splitter

This block sits between a software-facing write path and a flash array controller. A requester hands it a byte address and a byte count, neither of which needs any alignment. The block then pulls exactly that many bytes from a write-data stream and turns them into a series of hardware program operations. Each operation stays inside one 8-byte-aligned word and carries a byte-enable mask. Lanes that are not enabled are driven to all ones, so that programming (which can only clear bits) leaves those bytes untouched.

The block also keeps a program-operation count for every 256-byte row. When an operation would push a row past its budget, the block raises an error pulse and drops that operation. Only erasing the 8 KB sector that holds the row resets its count. A sector erase clears the counters of the 32 rows inside that sector.

Top module: `flash_prog_splitter`

## Requirements
- R1: Every issued operation has an address with bits [2:0] equal to zero and a non-zero byte mask whose set bits are contiguous. Mask bit i enables byte lane i, which is address op_addr+i.
- R2: Operations are issued in ascending address order. Each one covers min(8 - (a mod 8), remaining) bytes, where a is the current address. For example, 20 bytes at offset 0 give 8,8,4; at offset 4 they give 4,8,8; at offset 6 they give 2,8,8,2. Two bytes at offset 7 give two 1-byte operations.
- R3: Request byte k is placed in op_data bits [8*i+7:8*i], where i = (addr+k) mod 8 (little-endian lanes). Every lane whose mask bit is clear reads 8'hFF.
- R4: The write stream is consumed strictly in order. Exactly req_len bytes are taken per request, and wr_ready is high only while the block is busy collecting bytes.
- R5: While op_valid is high and op_ready is low, op_valid stays high and op_addr, op_mask and op_data do not change.
- R6: Row index = op_addr[ADDR_W-1:8]. An operation is issued only if its row has taken fewer than ROW_BUDGET accepted operations. Otherwise it is dropped, and budget_err pulses for one cycle. The bytes of a dropped operation are still consumed.
- R7: An accepted erase of sector s (erase_valid with erase_ready) resets the counts of rows 32*s to 32*s+31 and of no other row. erase_ready is high only while the block is idle.
- R8: A request with req_len = 0 issues no operation and takes no bytes. busy stays low, and done pulses on the cycle after acceptance.
- R9: After a non-zero request is accepted, busy is high from the next cycle until the last operation is accepted or dropped. done pulses for one cycle right after that, and req_ready is low whenever busy is high or erase_valid is high.
- R10: After reset the block is idle: busy, op_valid, done, budget_err and wr_ready are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to program |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_byte | input | 8 | Write data byte |
| erase_valid | input | 1 | Sector erase notification offered |
| erase_ready | output | 1 | Erase notification can be accepted |
| erase_sector | input | ADDR_W-13 | Index of the erased 8 KB sector |
| op_valid | output | 1 | Program operation available |
| op_ready | input | 1 | Program operation accepted |
| op_addr | output | ADDR_W | Word-aligned byte address of the operation |
| op_mask | output | 8 | Byte-enable mask, bit i for lane i |
| op_data | output | 64 | Little-endian word image, disabled lanes all ones |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| budget_err | output | 1 | One-cycle pulse when an operation is dropped for budget |

## Verification
The assertions assume that the requester follows the handshake rules. An offered operation stays offered only because the block holds it, and an erase notification arrives only when erase_ready is high. They also assume that each request fits in the address space without wrapping. The stimulus keeps to these limits: erases are issued only between requests, and every address plus length stays below the top of the address space. The reference model in the bench is a transaction-level description with per-row counts. It is compared against every operation handshake and every error pulse, with and without back-pressure on op_ready.

// File: rtl/flash_split_pkg.sv
package flash_split_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_LOG   = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_ISSUE  = 2'd2
    } split_state_e;

    typedef struct packed {
        logic [7:0]  mask;
        logic [63:0] data;
    } word_img_t;

    // bytes of the current chunk: limited by room left in the word and by what remains
    function automatic logic [3:0] chunk_len(input logic [2:0] off, input logic [3:0] rem_cap);
        logic [3:0] room;
        room = 4'd8 - {1'b0, off};
        return (rem_cap < room) ? rem_cap : room;
    endfunction

    function automatic logic [7:0] lane_mask(input logic [2:0] off, input logic [3:0] n);
        logic [7:0] m;
        logic [3:0] stop;
        stop = {1'b0, off} + n;
        for (int i = 0; i < 8; i++) begin
            m[i] = (4'(i) >= {1'b0, off}) && (4'(i) < stop);
        end
        return m;
    endfunction

    function automatic logic [63:0] expand_mask(input logic [7:0] m);
        logic [63:0] e;
        for (int i = 0; i < 8; i++) begin
            e[8*i +: 8] = {8{m[i]}};
        end
        return e;
    endfunction

endpackage

// File: rtl/fsp_cursor.sv
module fsp_cursor
    import flash_split_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [ADDR_W-1:0]          load_addr,
    input  logic [LEN_W-1:0]           load_len,
    input  logic                       step,
    output logic [ADDR_W-WORD_LOG-1:0] op_word,
    output logic [2:0]                 off,
    output logic [3:0]                 chunk_n,
    output logic                       last
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [3:0]        rem_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_len;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(chunk_n);
            rem_q  <= rem_q - LEN_W'(chunk_n);
        end
    end

    always_comb begin
        rem_cap = (rem_q >= LEN_W'(WORD_BYTES)) ? 4'd8 : rem_q[3:0];
        off     = addr_q[2:0];
        chunk_n = chunk_len(off, rem_cap);
        last    = (rem_q == LEN_W'(chunk_n));
        op_word = addr_q[ADDR_W-1:WORD_LOG];
    end
endmodule

// File: rtl/fsp_packer.sv
module fsp_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [2:0]  start_lane,
    input  logic        take,
    input  logic [7:0]  byte_in,
    output logic [63:0] img_data,
    output logic [3:0]  lane
);
    logic [63:0] data_q;
    logic [3:0]  lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '1;
            lane_q <= '0;
        end else if (load) begin
            data_q <= '1;
            lane_q <= {1'b0, start_lane};
        end else if (take) begin
            data_q[lane_q[2:0]*8 +: 8] <= byte_in;
            lane_q <= lane_q + 4'd1;
        end
    end

    assign img_data = data_q;
    assign lane     = lane_q;
endmodule

// File: rtl/fsp_row_budget.sv
module fsp_row_budget #(
    parameter int ROW_W   = 8,
    parameter int SUB_W   = 5,
    parameter int BUDGET  = 4,
    localparam int SEC_W    = ROW_W - SUB_W,
    localparam int NUM_ROWS = 1 << ROW_W,
    localparam int CNT_W    = $clog2(BUDGET + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] row_sel,
    input  logic             inc,
    input  logic             clr,
    input  logic [SEC_W-1:0] clr_sector,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt [NUM_ROWS];

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        localparam logic [ROW_W-1:0] RIDX = ROW_W'(r);
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[r] <= '0;
            end else if (clr && (RIDX[ROW_W-1:SUB_W] == clr_sector)) begin
                cnt[r] <= '0;
            end else if (inc && (row_sel == RIDX)) begin
                cnt[r] <= cnt[r] + CNT_W'(1);
            end
        end
    end

    assign at_limit = (cnt[row_sel] >= CNT_W'(BUDGET));
endmodule

// File: rtl/flash_prog_splitter.sv
module flash_prog_splitter
    import flash_split_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int LEN_W        = 12,
    parameter int ROW_BYTES    = 256,
    parameter int SECTOR_BYTES = 8192,
    parameter int ROW_BUDGET   = 4,
    localparam int ROW_LOG     = $clog2(ROW_BYTES),
    localparam int SEC_LOG     = $clog2(SECTOR_BYTES),
    localparam int ROW_W       = ADDR_W - ROW_LOG,
    localparam int SUB_W       = SEC_LOG - ROW_LOG,
    localparam int SEC_W       = ADDR_W - SEC_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_byte,
    input  logic              erase_valid,
    output logic              erase_ready,
    input  logic [SEC_W-1:0]  erase_sector,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_mask,
    output logic [63:0]       op_data,
    output logic              busy,
    output logic              done,
    output logic              budget_err
);
    split_state_e state_q;
    logic done_q, err_q;

    logic [ADDR_W-WORD_LOG-1:0] op_word;
    logic [2:0]  off;
    logic [3:0]  chunk_n;
    logic        last;
    logic [63:0] img_data;
    logic [3:0]  lane;
    logic        at_limit;
    word_img_t   img;

    logic req_fire, erase_fire, take, gathered, in_issue, op_fire, issue_end;
    logic pack_load;
    logic [2:0] pack_lane;

    always_comb begin
        req_ready   = (state_q == ST_IDLE) && !erase_valid;
        erase_ready = (state_q == ST_IDLE);
        req_fire    = req_valid && req_ready;
        erase_fire  = erase_valid && erase_ready;
        gathered    = (lane == ({1'b0, off} + chunk_n));
        wr_ready    = (state_q == ST_GATHER) && !gathered;
        take        = wr_valid && wr_ready;
        in_issue    = (state_q == ST_ISSUE);
        op_valid    = in_issue && !at_limit;
        op_fire     = op_valid && op_ready;
        issue_end   = in_issue && (op_fire || at_limit);
        pack_load   = req_fire || (issue_end && !last);
        pack_lane   = req_fire ? req_addr[2:0] : 3'd0;
        img.mask    = lane_mask(off, chunk_n);
        img.data    = img_data;
    end

    fsp_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .load      (req_fire),
        .load_addr (req_addr),
        .load_len  (req_len),
        .step      (issue_end),
        .op_word   (op_word),
        .off       (off),
        .chunk_n   (chunk_n),
        .last      (last)
    );

    fsp_packer u_packer (
        .clk        (clk),
        .rst        (rst),
        .load       (pack_load),
        .start_lane (pack_lane),
        .take       (take),
        .byte_in    (wr_byte),
        .img_data   (img_data),
        .lane       (lane)
    );

    fsp_row_budget #(.ROW_W(ROW_W), .SUB_W(SUB_W), .BUDGET(ROW_BUDGET)) u_budget (
        .clk        (clk),
        .rst        (rst),
        .row_sel    (op_word[ADDR_W-WORD_LOG-1:ROW_LOG-WORD_LOG]),
        .inc        (op_fire),
        .clr        (erase_fire),
        .clr_sector (erase_sector),
        .at_limit   (at_limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= (req_fire && (req_len == '0)) || (issue_end && last);
            err_q  <= in_issue && at_limit;
            unique case (state_q)
                ST_IDLE:   if (req_fire && (req_len != '0)) state_q <= ST_GATHER;
                ST_GATHER: if (gathered) state_q <= ST_ISSUE;
                ST_ISSUE:  if (issue_end) state_q <= last ? ST_IDLE : ST_GATHER;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign op_addr    = {op_word, {WORD_LOG{1'b0}}};
    assign op_mask    = img.mask;
    assign op_data    = img.data;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign budget_err = err_q;
endmodule

// File: rtl/flash_prog_splitter_chk.sv
module flash_prog_splitter_chk
    import flash_split_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              wr_ready,
    input logic              erase_ready,
    input logic              op_valid,
    input logic              op_ready,
    input logic [ADDR_W-1:0] op_addr,
    input logic [7:0]        op_mask,
    input logic [63:0]       op_data,
    input logic              busy,
    input logic              done,
    input logic              budget_err
);
    logic [7:0]  low_bit;
    logic [63:0] fill;

    always_comb begin
        low_bit = op_mask & (~op_mask + 8'd1);
        fill    = expand_mask(op_mask);
    end

    // R1
    op_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (op_addr[2:0] == 3'd0) && (op_mask != 8'd0));

    // R1
    mask_contig_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (((op_mask + low_bit) & op_mask) == 8'd0));

    // R3
    idle_lanes_ones_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> ((op_data | fill) == 64'hFFFF_FFFF_FFFF_FFFF));

    // R5
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_mask) && $stable(op_data));

    // R4
    wr_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> busy);

    // R9
    no_req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    err_no_op_chk: assert property (@(posedge clk) disable iff (rst)
        budget_err |-> !op_valid);

    // R7
    erase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        erase_ready |-> !busy);
endmodule

bind flash_prog_splitter flash_prog_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .wr_ready    (wr_ready),
    .erase_ready (erase_ready),
    .op_valid    (op_valid),
    .op_ready    (op_ready),
    .op_addr     (op_addr),
    .op_mask     (op_mask),
    .op_data     (op_data),
    .busy        (busy),
    .done        (done),
    .budget_err  (budget_err)
);

// File: tb/flash_prog_splitter_tb.sv
module flash_prog_splitter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int BUDGET = 4;
    localparam int SEC_W  = ADDR_W - 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] wr_byte = '0;
    logic erase_valid = 1'b0, erase_ready;
    logic [SEC_W-1:0] erase_sector = '0;
    logic op_valid, op_ready = 1'b1;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0] op_mask;
    logic [63:0] op_data;
    logic busy, done, budget_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_BUDGET(BUDGET)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .erase_valid(erase_valid), .erase_ready(erase_ready), .erase_sector(erase_sector),
        .op_valid(op_valid), .op_ready(op_ready), .op_addr(op_addr), .op_mask(op_mask),
        .op_data(op_data), .busy(busy), .done(done), .budget_err(budget_err)
    );

    typedef struct {
        int unsigned addr;
        logic [7:0]  mask;
        logic [63:0] data;
        bit          sup;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] byte_q[$];
    int rowcnt[256];
    int checks = 0, errors = 0;
    int bval = 1;
    int op_cnt = 0, err_cnt = 0;
    bit done_seen = 0;
    bit ready_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    bit f_wr, f_op, f_req, f_erase;
    logic [ADDR_W-1:0] c_addr;
    logic [7:0] c_mask;
    logic [63:0] c_data;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic drive_streams();
        wr_valid = (byte_q.size() > 0);
        wr_byte  = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
        op_ready = ready_mode ? lfsr[0] : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    // one clock: capture handshakes after inputs settle, then compare at the falling edge
    task automatic cycle();
        exp_t e;
        #1;
        f_wr = wr_valid && wr_ready;
        f_op = op_valid && op_ready;
        f_req = req_valid && req_ready;
        f_erase = erase_valid && erase_ready;
        c_addr = op_addr; c_mask = op_mask; c_data = op_data;
        @(negedge clk);
        if (f_wr) void'(byte_q.pop_front());
        if (f_op) begin
            op_cnt++;
            if (exp_q.size() == 0) chk(0, "R2 unexpected op", 64'(c_addr), 64'hFFFF);
            else begin
                e = exp_q.pop_front();
                chk(!e.sup, "R6 op issued over budget", 64'(c_addr), 64'(e.addr));
                chk(c_addr == ADDR_W'(e.addr), "R1 R2 op address", 64'(c_addr), 64'(e.addr));
                chk(c_mask == e.mask, "R1 R2 op mask", 64'(c_mask), 64'(e.mask));
                chk(c_data == e.data, "R3 op data", c_data, e.data);
            end
        end
        if (budget_err) begin
            err_cnt++;
            if (exp_q.size() == 0 || !exp_q[0].sup)
                chk(0, "R6 unexpected budget_err", 64'd1, 64'd0);
            else begin
                e = exp_q.pop_front();
                chk(1, "R6 drop", 64'd1, 64'd1);
            end
        end
        if (done) done_seen = 1;
        drive_streams();
    endtask

    task automatic plan(input int unsigned addr, input int unsigned len);
        int unsigned a = addr;
        int unsigned rem = len;
        while (rem > 0) begin
            exp_t e;
            int unsigned off = a % 8;
            int unsigned n = ((8 - off) < rem) ? (8 - off) : rem;
            int row = (a / 256) % 256;
            e.addr = a - off;
            e.mask = '0;
            e.data = '1;
            for (int unsigned k = 0; k < n; k++) begin
                logic [7:0] b = 8'(bval * 29 + 3);
                bval++;
                byte_q.push_back(b);
                e.mask[off + k] = 1'b1;
                e.data[8*(off+k) +: 8] = b;
            end
            if (rowcnt[row] >= BUDGET) e.sup = 1;
            else begin e.sup = 0; rowcnt[row]++; end
            exp_q.push_back(e);
            a += n;
            rem -= n;
        end
    endtask

    task automatic do_req(input int unsigned addr, input int unsigned len,
                          input int exp_ops, input int exp_errs, input string tag);
        int n = 0;
        int ops0 = op_cnt;
        int errs0 = err_cnt;
        plan(addr, len);
        drive_streams();
        req_addr = ADDR_W'(addr);
        req_len = LEN_W'(len);
        req_valid = 1;
        done_seen = 0;
        do begin cycle(); n++; end while (!f_req && n < 100);
        req_valid = 0;
        chk(f_req, {tag, " R9 accepted"}, 64'(f_req), 64'd1);
        chk(busy == (len != 0), {tag, (len == 0) ? " R8 busy" : " R9 busy"}, 64'(busy), 64'(len != 0));
        if (len != 0) chk(!req_ready, {tag, " R9 req_ready while busy"}, 64'(req_ready), 64'd0);
        n = 0;
        while (!done_seen && n < 2000) begin cycle(); n++; end
        chk(done_seen, {tag, " R9 done"}, 64'(done_seen), 64'd1);
        chk(exp_q.size() == 0, {tag, " R2 ops left"}, 64'(exp_q.size()), 64'd0);
        chk(byte_q.size() == 0, {tag, " R4 bytes left"}, 64'(byte_q.size()), 64'd0);
        chk(!busy && !wr_ready, {tag, " R4 idle after done"}, 64'({busy, wr_ready}), 64'd0);
        cycle();
        chk(!done, {tag, " R9 done one cycle"}, 64'(done), 64'd0);
        if (exp_ops >= 0) chk(op_cnt - ops0 == exp_ops, {tag, " R2 op count"}, 64'(op_cnt - ops0), 64'(exp_ops));
        if (exp_errs >= 0) chk(err_cnt - errs0 == exp_errs, {tag, " R6 err count"}, 64'(err_cnt - errs0), 64'(exp_errs));
    endtask

    task automatic do_erase(input int s);
        int n = 0;
        erase_sector = SEC_W'(s);
        erase_valid = 1;
        do begin cycle(); n++; end while (!f_erase && n < 100);
        erase_valid = 0;
        chk(f_erase, "R7 erase accepted", 64'(f_erase), 64'd1);
        for (int r = 0; r < 32; r++) rowcnt[s*32 + r] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        for (int r = 0; r < 256; r++) rowcnt[r] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !op_valid && !done && !budget_err && !wr_ready,
            "R10 idle outputs", 64'({busy, op_valid, done, budget_err, wr_ready}), 64'd0);
        chk(req_ready && erase_ready, "R10 ready", 64'({req_ready, erase_ready}), 64'd3);

        do_req(32'h0100, 20, 3, 0, "R2 aligned 20");
        do_req(32'h0204, 20, 3, 0, "R2 off4 20");
        do_req(32'h0306, 20, 4, 0, "R2 off6 20");
        do_req(32'h0407, 2, 2, 0, "R2 off7 2");
        do_req(32'h0455, 0, 0, 0, "R8 zero length");

        for (int i = 0; i < 4; i++) do_req(32'h0500, 8, 1, 0, "R6 within budget");
        do_req(32'h0503, 3, 0, 1, "R6 over budget");
        do_erase(0);
        do_req(32'h0500, 8, 1, 0, "R7 after erase");

        for (int i = 0; i < 4; i++) do_req(32'h2000, 8, 1, 0, "R6 fill sector1 row");
        do_erase(0);
        do_req(32'h2001, 3, 0, 1, "R7 other sector untouched");
        do_erase(1);
        do_req(32'h2001, 3, 1, 0, "R7 sector1 erased");

        do_req(32'h06FC, 8, 2, 0, "R2 row crossing");

        ready_mode = 1;
        do_req(32'h0805, 24, 4, 0, "R5 backpressure");
        do_erase(2);
        do_erase(3);
        for (int i = 0; i < 40; i++)
            do_req(32'h4000 + i * 37 + (i % 5), (i * 13) % 41, -1, -1, "R3 mixed");
        ready_mode = 0;

        summary();
        $finish;
    end
endmodule